// File: doc/BRIEF.md
# Flash Operation Sequencer

This block sits between a 32-bit register bus and the control pins of an embedded nonvolatile memory macro. Software loads clock-count fields into three timing registers and sets a target address. It then writes a command word to the control register. The block decodes that word, picks exactly one operation (mass erase, page erase, program, reference-cell erase or trim recall) and walks it through a short setup phase, a main phase and, for erase and program, a hold phase. The length of each phase comes from the loaded counts.

While an operation runs, a busy flag is visible both on a pin and in bit 0 of the status register. The flag drops by itself when the last phase ends, and software polls for that. Register writes that arrive during an operation are dropped, so a running operation cannot be disturbed. A write-protect bit in the control register locks the timing and address registers and blocks new operations until software clears it. A sleep bit is passed straight through to the macro.

Top module: `flash_op_seq`

## Requirements
- R1: After reset, busy is low, no strobe or hold pin is active, and reads of the control, status and timing registers return zero.
- R2: Registers are at byte offsets 0x00 control, 0x04 timing0, 0x08 timing1, 0x0C timing2, 0x20 address and 0x2C status. Field layout: timing0 has hold count [31:16] and wait states [5:0]; timing1 has erase count [23:0]; timing2 has 10 ns ticks [27:24], 100 ns ticks [23:16] and program count [15:0]. Unused bits read as zero. A read returns data one cycle after it is issued. `fm_wait` mirrors the wait-state field.
- R3: The control operation bits are mass erase (3), page erase (4), program (5), reference erase (6) and trim recall (7). When several are set, only one starts, in that priority order (lowest bit first). During the main phase exactly one strobe is high: `fm_strobe[0]` for mass erase, `[1]` for page erase, `[2]` for program, `[3]` for reference erase and `[4]` for recall. A control write with no operation bit starts nothing.
- R4: An operation first spends max(T10,1) cycles in setup. It then spends max(N,1) cycles in the main phase with its strobe high. N is the program count for program, the 100 ns tick count for recall, and the erase count for the three erase kinds.
- R5: Erase and program are followed by max(H,1) cycles with `fm_hold` high, where H is the hold count. Recall has no hold phase. Busy is high from the cycle after the control write to the end of the last phase.
- R6: Status bit 0 reads 1 exactly while busy. While busy, the control register reads back only the bit of the running operation. That bit reads 0 once the operation ends.
- R7: While busy, every register write is ignored. This covers control, timing and address writes, and the running operation's length is unchanged.
- R8: While control bit 1 (write protect) is set, writes to the timing and address registers are ignored and operation bits start nothing. Control writes still update the sleep, protect and auto-advance bits.
- R9: While busy, `fm_addr` is zero for mass erase, the address rounded down to a 4096-byte page for page erase, and the address register otherwise. When idle, it is the address register.
- R10: With control bit 8 (auto-advance) set, a completed program operation adds 32 to the address register. Other operations leave the address unchanged.
- R11: Control bit 0 (sleep) drives `fm_sleep` and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| op_busy | output | 1 | Operation in progress |
| fm_strobe | output | 5 | One-hot main-phase strobe per operation |
| fm_hold | output | 1 | Nonvolatile hold phase active |
| fm_addr | output | FADDR_W | Address presented to the macro |
| fm_sleep | output | 1 | Macro low-power request |
| fm_wait | output | 6 | Read wait-state setting |

## Verification
The bench targets these corner cases:
- Zero counts in every phase. A design that lets a zero count underflow would hang busy for millions of cycles.
- Control words with several operation bits set. Wrong priority wiring would light the wrong strobe.
- Control and timing writes landing mid-operation. A design that accepts them would restart the counters or change the phase length, and the busy window would come out longer than the computed value.
- The page-rounding and mass-erase address forms, and an auto-advance that must happen only after program. These catch an address path that ignores the running operation or advances on the wrong completion.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

  localparam int CNT_W = 24;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_TIM0 = 8'h04;
  localparam logic [7:0] OFF_TIM1 = 8'h08;
  localparam logic [7:0] OFF_TIM2 = 8'h0C;
  localparam logic [7:0] OFF_ADDR = 8'h20;
  localparam logic [7:0] OFF_STAT = 8'h2C;

  localparam int CB_SLEEP  = 0;
  localparam int CB_WP     = 1;
  localparam int CB_MASS   = 3;
  localparam int CB_PAGE   = 4;
  localparam int CB_PROG   = 5;
  localparam int CB_REF    = 6;
  localparam int CB_RECALL = 7;
  localparam int CB_AUTO   = 8;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_MASS   = 3'd1,
    OP_PAGE   = 3'd2,
    OP_PROG   = 3'd3,
    OP_REF    = 3'd4,
    OP_RECALL = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_MAIN  = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [15:0] nvh;
    logic [5:0]  wait_st;
    logic [23:0] erase;
    logic [3:0]  t10;
    logic [7:0]  t100;
    logic [15:0] prog;
  } timing_t;

  // Lowest control bit wins.
  function automatic op_e pick_op(input logic [31:0] w);
    if (w[CB_MASS])        return OP_MASS;
    else if (w[CB_PAGE])   return OP_PAGE;
    else if (w[CB_PROG])   return OP_PROG;
    else if (w[CB_REF])    return OP_REF;
    else if (w[CB_RECALL]) return OP_RECALL;
    else                   return OP_NONE;
  endfunction

endpackage

// File: rtl/flseq_regs.sv
module flseq_regs
  import flseq_pkg::*;
#(
  parameter int FADDR_W   = 20,
  parameter int ROW_BYTES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               busy,
  input  logic               fin,
  input  op_e                fin_op,
  output timing_t            tim,
  output logic [FADDR_W-1:0] addr_q,
  output logic               sleep_q,
  output logic               wp_q,
  output logic               auto_q,
  output logic               start,
  output op_e                start_op
);

  localparam logic [FADDR_W-1:0] ROW_STEP = FADDR_W'(ROW_BYTES);

  logic ctrl_hit;
  logic cfg_ok;
  op_e  req_op;

  assign req_op   = pick_op(wr_data);
  assign ctrl_hit = wr_en && (wr_addr == OFF_CTRL) && !busy;
  assign cfg_ok   = wr_en && !busy && !wp_q;
  assign start    = ctrl_hit && !wp_q && (req_op != OP_NONE);
  assign start_op = req_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim     <= '0;
      addr_q  <= '0;
      sleep_q <= 1'b0;
      wp_q    <= 1'b0;
      auto_q  <= 1'b0;
    end else begin
      if (ctrl_hit) begin
        sleep_q <= wr_data[CB_SLEEP];
        wp_q    <= wr_data[CB_WP];
        auto_q  <= wr_data[CB_AUTO];
      end
      if (cfg_ok && wr_addr == OFF_TIM0) begin
        tim.nvh     <= wr_data[31:16];
        tim.wait_st <= wr_data[5:0];
      end
      if (cfg_ok && wr_addr == OFF_TIM1) begin
        tim.erase <= wr_data[23:0];
      end
      if (cfg_ok && wr_addr == OFF_TIM2) begin
        tim.t10  <= wr_data[27:24];
        tim.t100 <= wr_data[23:16];
        tim.prog <= wr_data[15:0];
      end
      if (cfg_ok && wr_addr == OFF_ADDR) begin
        addr_q <= wr_data[FADDR_W-1:0];
      end else if (fin && fin_op == OP_PROG && auto_q) begin
        addr_q <= addr_q + ROW_STEP;
      end
    end
  end

endmodule

// File: rtl/flseq_seq.sv
module flseq_seq
  import flseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  op_e     start_op,
  input  timing_t tim,
  output phase_e  phase,
  output op_e     cur_op,
  output logic    busy,
  output logic    fin
);

  phase_e           ph_q;
  op_e              op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;
  logic [CNT_W-1:0] main_len;
  logic             unused_wait;

  assign unused_wait = ^tim.wait_st;

  // A count of zero behaves as one cycle.
  assign last = (cnt_q <= CNT_W'(1));

  always_comb begin
    case (op_q)
      OP_PROG:   main_len = CNT_W'(tim.prog);
      OP_RECALL: main_len = CNT_W'(tim.t100);
      default:   main_len = tim.erase;
    endcase
  end

  assign fin    = last && ((ph_q == PH_HOLD) ||
                           (ph_q == PH_MAIN && op_q == OP_RECALL));
  assign busy   = (ph_q != PH_IDLE);
  assign phase  = ph_q;
  assign cur_op = op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      op_q  <= OP_NONE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start) begin
            ph_q  <= PH_SETUP;
            op_q  <= start_op;
            cnt_q <= CNT_W'(tim.t10);
          end
        end
        PH_SETUP: begin
          if (!last) cnt_q <= cnt_q - 1'b1;
          else begin
            ph_q  <= PH_MAIN;
            cnt_q <= main_len;
          end
        end
        PH_MAIN: begin
          if (!last) cnt_q <= cnt_q - 1'b1;
          else if (op_q == OP_RECALL) ph_q <= PH_IDLE;
          else begin
            ph_q  <= PH_HOLD;
            cnt_q <= CNT_W'(tim.nvh);
          end
        end
        default: begin
          if (!last) cnt_q <= cnt_q - 1'b1;
          else       ph_q  <= PH_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/flseq_rdback.sv
module flseq_rdback
  import flseq_pkg::*;
#(
  parameter int FADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [7:0]         rd_addr,
  input  timing_t            tim,
  input  logic [FADDR_W-1:0] addr_q,
  input  logic               sleep_q,
  input  logic               wp_q,
  input  logic               auto_q,
  input  logic               busy,
  input  op_e                cur_op,
  output logic [31:0]        rdata
);

  logic [31:0] v;

  always_comb begin
    v = '0;
    case (rd_addr)
      OFF_CTRL: begin
        v[CB_SLEEP] = sleep_q;
        v[CB_WP]    = wp_q;
        v[CB_AUTO]  = auto_q;
        if (busy) begin
          case (cur_op)
            OP_MASS:   v[CB_MASS]   = 1'b1;
            OP_PAGE:   v[CB_PAGE]   = 1'b1;
            OP_PROG:   v[CB_PROG]   = 1'b1;
            OP_REF:    v[CB_REF]    = 1'b1;
            OP_RECALL: v[CB_RECALL] = 1'b1;
            default:   ;
          endcase
        end
      end
      OFF_TIM0: v = {tim.nvh, 10'd0, tim.wait_st};
      OFF_TIM1: v = {8'd0, tim.erase};
      OFF_TIM2: v = {4'd0, tim.t10, tim.t100, tim.prog};
      OFF_ADDR: v = 32'(addr_q);
      OFF_STAT: v = {31'd0, busy};
      default:  v = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= v;
  end

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flseq_pkg::*;
#(
  parameter int FADDR_W    = 20,
  parameter int PAGE_BYTES = 4096,
  parameter int ROW_BYTES  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               op_busy,
  output logic [4:0]         fm_strobe,
  output logic               fm_hold,
  output logic [FADDR_W-1:0] fm_addr,
  output logic               fm_sleep,
  output logic [5:0]         fm_wait
);

  localparam int NUM_OPS = 5;
  localparam logic [FADDR_W-1:0] PAGE_MASK = ~(FADDR_W'(PAGE_BYTES - 1));

  timing_t            tim;
  logic [FADDR_W-1:0] addr_q;
  logic               sleep_q, wp_q, auto_q;
  logic               start, fin, busy;
  op_e                start_op, cur_op;
  phase_e             phase;

  flseq_regs #(.FADDR_W(FADDR_W), .ROW_BYTES(ROW_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .busy(busy), .fin(fin), .fin_op(cur_op),
    .tim(tim), .addr_q(addr_q), .sleep_q(sleep_q), .wp_q(wp_q),
    .auto_q(auto_q), .start(start), .start_op(start_op)
  );

  flseq_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_op(start_op), .tim(tim),
    .phase(phase), .cur_op(cur_op), .busy(busy), .fin(fin)
  );

  flseq_rdback #(.FADDR_W(FADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_en(bus_rd), .rd_addr(bus_addr),
    .tim(tim), .addr_q(addr_q), .sleep_q(sleep_q), .wp_q(wp_q),
    .auto_q(auto_q), .busy(busy), .cur_op(cur_op),
    .rdata(bus_rdata)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_strobe
    assign fm_strobe[g] = (phase == PH_MAIN) && (cur_op == op_e'(3'(g + 1)));
  end

  always_comb begin
    fm_addr = addr_q;
    if (busy) begin
      case (cur_op)
        OP_MASS: fm_addr = '0;
        OP_PAGE: fm_addr = addr_q & PAGE_MASK;
        default: fm_addr = addr_q;
      endcase
    end
  end

  assign op_busy  = busy;
  assign fm_hold  = (phase == PH_HOLD);
  assign fm_sleep = sleep_q;
  assign fm_wait  = tim.wait_st;

endmodule

// File: rtl/flseq_chk.sv
module flseq_chk
  import flseq_pkg::*;
#(
  parameter int FADDR_W    = 20,
  parameter int PAGE_BYTES = 4096
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [7:0]         bus_addr,
  input logic               op_busy,
  input logic [4:0]         fm_strobe,
  input logic               fm_hold,
  input logic [FADDR_W-1:0] fm_addr,
  input logic               fm_sleep
);

  localparam int PAGE_LSB = $clog2(PAGE_BYTES);

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fm_strobe));

  a_r3_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_busy) |-> $past(bus_wr && bus_addr == OFF_CTRL));

  a_r4_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|fm_strobe) |-> op_busy);

  a_r5_hold_apart: assert property (@(posedge clk) disable iff (!rst_n)
    fm_hold |-> (op_busy && fm_strobe == '0));

  a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && $past(op_busy)) |-> $stable(fm_addr));

  a_r9_mass_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fm_strobe[0] |-> (fm_addr == '0));

  a_r9_page_align: assert property (@(posedge clk) disable iff (!rst_n)
    fm_strobe[1] |-> (fm_addr[PAGE_LSB-1:0] == '0));

  a_r11_sleep_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && $past(op_busy)) |-> $stable(fm_sleep));

endmodule

bind flash_op_seq flseq_chk #(.FADDR_W(FADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .op_busy(op_busy), .fm_strobe(fm_strobe), .fm_hold(fm_hold),
  .fm_addr(fm_addr), .fm_sleep(fm_sleep)
);

// File: tb/sim_flash_op_seq.sv
module sim_flash_op_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  localparam logic [31:0] V_CTRL [NV] = '{32'h20, 32'h10, 32'h08, 32'h40,
                                          32'h80, 32'hE0, 32'h18, 32'h00};
  localparam int V_T10   [NV] = '{2, 3, 1, 0, 2, 1, 1, 2};
  localparam int V_PROG  [NV] = '{5, 1, 1, 1, 1, 4, 1, 1};
  localparam int V_ERASE [NV] = '{9, 9, 6, 0, 1, 1, 3, 1};
  localparam int V_NVH   [NV] = '{3, 2, 1, 0, 1, 2, 1, 1};
  localparam int V_T100  [NV] = '{4, 4, 4, 4, 7, 4, 4, 4};
  localparam int V_CYC   [NV] = '{10, 14, 8, 3, 9, 7, 5, 0};
  localparam logic [4:0] V_STB [NV] = '{5'b00100, 5'b00010, 5'b00001, 5'b01000,
                                        5'b10000, 5'b00100, 5'b00001, 5'b00000};
  localparam logic V_HOLD [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        op_busy;
  logic [4:0]  fm_strobe;
  logic        fm_hold;
  logic [19:0] fm_addr;
  logic        fm_sleep;
  logic [5:0]  fm_wait;

  int n_tests = 0;
  int n_fail  = 0;

  flash_op_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .op_busy(op_busy), .fm_strobe(fm_strobe), .fm_hold(fm_hold),
    .fm_addr(fm_addr), .fm_sleep(fm_sleep), .fm_wait(fm_wait)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic set_timing(input int t10, input int prog, input int erase,
                            input int nvh, input int t100, input int wst);
    bus_write(8'h04, {nvh[15:0], 10'd0, wst[5:0]});
    bus_write(8'h08, {8'd0, erase[23:0]});
    bus_write(8'h0C, {4'd0, t10[3:0], t100[7:0], prog[15:0]});
  endtask

  // Counts busy cycles from the negedge after the starting write;
  // optionally injects one write at busy cycle inj_at.
  task automatic watch(input int inj_at, input logic [7:0] ia, input logic [31:0] id,
                       output int cyc, output logic [4:0] stb, output logic hold,
                       output logic [19:0] sa);
    cyc = 0; stb = '0; hold = 1'b0; sa = '0;
    while (op_busy && cyc < 5000) begin
      cyc++;
      stb |= fm_strobe;
      hold |= fm_hold;
      if (|fm_strobe) sa = fm_addr;
      if (cyc == inj_at) begin
        bus_wr = 1'b1; bus_addr = ia; bus_wdata = id;
      end else begin
        bus_wr = 1'b0;
      end
      @(negedge clk);
    end
    bus_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          cyc;
    logic [4:0]  stb;
    logic        hold;
    logic [19:0] sa;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", 32'(op_busy), 0);
    chk("R1 strobe", 32'(fm_strobe), 0);
    chk("R1 hold", 32'(fm_hold), 0);
    bus_read(8'h2C, rd); chk("R1 status", rd, 0);
    bus_read(8'h00, rd); chk("R1 control", rd, 0);
    bus_read(8'h08, rd); chk("R1 timing1", rd, 0);

    // R2 field layout and readback
    set_timing(3, 16'h1234, 24'hABCDEF, 16'h5678, 8'h9A, 6'h2A);
    bus_read(8'h04, rd); chk("R2 timing0", rd, 32'h5678_002A);
    bus_read(8'h08, rd); chk("R2 timing1", rd, 32'h00AB_CDEF);
    bus_read(8'h0C, rd); chk("R2 timing2", rd, 32'h039A_1234);
    chk("R2 fm_wait", 32'(fm_wait), 32'h2A);
    bus_write(8'h08, 32'hFFAB_CDEF);
    bus_read(8'h08, rd); chk("R2 timing1 upper bits", rd, 32'h00AB_CDEF);

    // R3 R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      set_timing(V_T10[i], V_PROG[i], V_ERASE[i], V_NVH[i], V_T100[i], 0);
      bus_write(8'h00, V_CTRL[i]);
      watch(0, 8'h00, 32'h0, cyc, stb, hold, sa);
      chk("R4 R5 busy cycles", 32'(cyc), 32'(V_CYC[i]));
      chk("R3 strobe select", 32'(stb), 32'(V_STB[i]));
      chk("R5 hold phase", 32'(hold), 32'(V_HOLD[i]));
      bus_read(8'h2C, rd); chk("R6 status idle", rd, 0);
    end

    // R6 readback while running
    set_timing(1, 20, 1, 5, 4, 0);
    bus_write(8'h00, 32'hA0);
    bus_read(8'h00, rd); chk("R6 control running", rd, 32'h20);
    bus_read(8'h2C, rd); chk("R6 status busy", rd, 1);
    watch(0, 8'h00, 32'h0, cyc, stb, hold, sa);
    bus_read(8'h00, rd); chk("R6 control self-clear", rd, 0);
    bus_read(8'h2C, rd); chk("R6 status done", rd, 0);

    // R7 writes ignored while busy
    bus_write(8'h20, 32'h400);
    set_timing(1, 30, 1, 2, 4, 0);
    bus_write(8'h00, 32'h20);
    watch(5, 8'h00, 32'h08, cyc, stb, hold, sa);
    chk("R7 control write ignored cycles", 32'(cyc), 33);
    chk("R7 control write ignored strobe", 32'(stb), 32'b00100);
    @(negedge clk);
    chk("R7 no late start", 32'(op_busy), 0);
    bus_write(8'h00, 32'h20);
    watch(4, 8'h08, 32'h77, cyc, stb, hold, sa);
    bus_read(8'h08, rd); chk("R7 timing write ignored", rd, 1);
    bus_write(8'h00, 32'h20);
    watch(3, 8'h20, 32'h999, cyc, stb, hold, sa);
    bus_read(8'h20, rd); chk("R7 address write ignored", rd, 32'h400);

    // R8 write protect
    bus_write(8'h00, 32'h02);
    bus_write(8'h08, 32'h99);
    bus_read(8'h08, rd); chk("R8 timing locked", rd, 1);
    bus_write(8'h00, 32'h22);
    chk("R8 no start", 32'(op_busy), 0);
    bus_read(8'h00, rd); chk("R8 control", rd, 32'h02);
    bus_write(8'h20, 32'h700);
    bus_read(8'h20, rd); chk("R8 address locked", rd, 32'h400);
    bus_write(8'h00, 32'h00);
    bus_write(8'h08, 32'h99);
    bus_read(8'h08, rd); chk("R8 unlocked", rd, 32'h99);

    // R9 address forms
    set_timing(1, 2, 2, 1, 4, 0);
    bus_write(8'h20, 32'h12345);
    bus_write(8'h00, 32'h10);
    watch(0, 8'h00, 32'h0, cyc, stb, hold, sa);
    chk("R9 page aligned", 32'(sa), 32'h12000);
    bus_write(8'h00, 32'h08);
    watch(0, 8'h00, 32'h0, cyc, stb, hold, sa);
    chk("R9 mass zero", 32'(sa), 0);
    bus_write(8'h00, 32'h20);
    watch(0, 8'h00, 32'h0, cyc, stb, hold, sa);
    chk("R9 program address", 32'(sa), 32'h12345);
    chk("R9 idle address", 32'(fm_addr), 32'h12345);

    // R10 auto-advance
    bus_write(8'h00, 32'h120);
    watch(0, 8'h00, 32'h0, cyc, stb, hold, sa);
    bus_read(8'h20, rd); chk("R10 advanced", rd, 32'h12365);
    bus_read(8'h00, rd); chk("R10 auto bit kept", rd, 32'h100);
    bus_write(8'h00, 32'h110);
    watch(0, 8'h00, 32'h0, cyc, stb, hold, sa);
    bus_read(8'h20, rd); chk("R10 erase no advance", rd, 32'h12365);
    bus_write(8'h00, 32'h20);
    watch(0, 8'h00, 32'h0, cyc, stb, hold, sa);
    bus_read(8'h20, rd); chk("R10 auto off", rd, 32'h12365);

    // R11 sleep
    bus_write(8'h00, 32'h01);
    chk("R11 sleep pin", 32'(fm_sleep), 1);
    bus_read(8'h00, rd); chk("R11 sleep readback", rd, 1);
    bus_write(8'h00, 32'h00);
    chk("R11 wake", 32'(fm_sleep), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule